// File: doc/BRIEF.md
# Security Register Access Controller

This block sits behind a serial memory's command front end and serves a 512-byte security register. The front end has already shifted in the opcode and address. It hands them over with a one-cycle start pulse, then passes each data byte with a strobe, and marks the end of the command with an end pulse. Address bit 10 of the captured address selects what each of the two security opcodes does. With opcode 0x83, the block either reads register bytes or returns a lock-status byte. With opcode 0x82, it either writes the user page or applies a permanent lock.

The lower half of the register is a factory area. It holds a 128-bit serial number, supplied as a parameter, and the rest of that half reads as erased. The upper half is a 256-byte user page, held in flops inside the block. A write is accepted only when all of these hold:

- the write-enable latch input is set,
- the lock is not yet set,
- the protection inputs do not select full legacy block protection.

The lock is one-way. Only a power-on reset clears it.

Top module: `secreg_ctrl`

## Requirements
- R1: After reset, lock_flag and rd_valid are 0 and every user-page byte reads 0xFF.
- R2: On cmd_start, the opcode and address bit 10 select the command. 0x83 with bit 10 = 0 is a data read. 0x83 with bit 10 = 1 is a lock-status read. 0x82 with bit 10 = 0 is a user-page write. 0x82 with bit 10 = 1 is a lock request. Any other opcode makes the following data bytes have no effect and produce no rd_valid.
- R3: In a read or status command, each byte_valid gives rd_valid = 1 with rd_data exactly one clock later. rd_valid is 0 in every other cycle.
- R4: A data read uses the low 9 address bits. Offsets 0x000–0x00F return serial byte k = SERIAL_ID[8k+7:8k]. Offsets 0x010–0x0FF return 0xFF. Offsets 0x100–0x1FF return user-page byte offset[7:0]. The offset increments after each byte and wraps from 0x1FF to 0x000.
- R5: A lock-status read returns 0x01 for each byte when locked and 0x00 when not.
- R6: A user-page write stores each byte at offset[7:0]. Only the low 8 offset bits increment, so 0x1FF is followed by 0x100.
- R7: Writes whose offset lies in 0x000–0x0FF never change any readable byte.
- R8: Writes and lock requests have no effect while wel is 0 or lock_flag is 1.
- R9: When legacy_mode = 1 and bp = 2'b11, writes and lock requests have no effect. Any other combination of these inputs does not block them.
- R10: A lock request sets lock_flag one clock after a data byte with bit 1 set. A byte with bit 1 clear does nothing. Once set, lock_flag stays 1 until rst_n.
- R11: A byte strobed in the same cycle as cmd_start is ignored. After cmd_end, further bytes have no effect until the next cmd_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_start | input | 1 | New command: cmd_op and cmd_addr are valid |
| cmd_op | input | 8 | Decoded opcode |
| cmd_addr | input | ADDR_W | Captured command address |
| cmd_end | input | 1 | Command terminated (chip select released) |
| byte_valid | input | 1 | Data byte strobe |
| byte_in | input | 8 | Incoming data byte |
| wel | input | 1 | Write-enable latch state |
| legacy_mode | input | 1 | Legacy protection mode selected |
| bp | input | 2 | Block-protect bits |
| rd_data | output | 8 | Returned data byte |
| rd_valid | output | 1 | rd_data valid for the previous byte strobe |
| lock_flag | output | 1 | Security register permanently locked |

## Verification
The assertions watch the lock on every cycle. They check that lock_flag never falls once set. They also check that it rises only one clock after a strobed byte whose bit 1 is set, with wel high and legacy full protection off. A further assertion checks that rd_valid never appears without a strobed byte in the previous cycle. The values themselves can only be shown by the bench's scenarios:

- serial-number byte order and the 0xFF fill,
- both address wrap widths,
- rejection of writes to the factory half,
- status bytes before and after the lock.

// File: rtl/secreg_pkg.sv
package secreg_pkg;

    typedef enum logic [2:0] {
        M_IDLE,
        M_READ,
        M_STAT,
        M_WRITE,
        M_LOCK
    } mode_e;

endpackage

// File: rtl/secreg_decode.sv
module secreg_decode
    import secreg_pkg::*;
#(
    parameter logic [7:0] OP_RD = 8'h83,
    parameter logic [7:0] OP_WR = 8'h82
) (
    input  logic [7:0] op,
    input  logic       sel,
    output mode_e      mode
);
    always_comb begin
        if (op == OP_RD) begin
            mode = sel ? M_STAT : M_READ;
        end else if (op == OP_WR) begin
            mode = sel ? M_LOCK : M_WRITE;
        end else begin
            mode = M_IDLE;
        end
    end
endmodule

// File: rtl/secreg_serial_rom.sv
module secreg_serial_rom #(
    parameter int          SERIAL_BYTES = 16,
    parameter int          IDX_W        = 8,
    parameter logic [8*SERIAL_BYTES-1:0] SERIAL_ID = '0
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       data
);
    localparam int SN_W = (SERIAL_BYTES > 1) ? $clog2(SERIAL_BYTES) : 1;

    logic [7:0] sn [SERIAL_BYTES];

    for (genvar k = 0; k < SERIAL_BYTES; k++) begin : g_sn
        assign sn[k] = SERIAL_ID[8*k +: 8];
    end

    always_comb begin
        if (idx < IDX_W'(SERIAL_BYTES)) begin
            data = sn[idx[SN_W-1:0]];
        end else begin
            data = 8'hFF;
        end
    end
endmodule

// File: rtl/secreg_user_page.sv
module secreg_user_page #(
    parameter int PAGE_BYTES = 256,
    parameter int IDX_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] cells [PAGE_BYTES];

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[i] <= 8'hFF;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                cells[i] <= wr_data;
            end
        end
    end

    assign rd_data = cells[rd_idx];
endmodule

// File: rtl/secreg_ctrl.sv
module secreg_ctrl
    import secreg_pkg::*;
#(
    parameter int          ADDR_W       = 24,
    parameter int          SEL_BIT      = 10,
    parameter int          PAGE_BYTES   = 256,
    parameter int          SERIAL_BYTES = 16,
    parameter logic [7:0]  OP_RD        = 8'h83,
    parameter logic [7:0]  OP_WR        = 8'h82,
    parameter logic [8*SERIAL_BYTES-1:0] SERIAL_ID = {SERIAL_BYTES{8'hA5}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_end,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    input  logic              wel,
    input  logic              legacy_mode,
    input  logic [1:0]        bp,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              lock_flag
);
    localparam int IDX_W  = $clog2(PAGE_BYTES);
    localparam int AOFF_W = IDX_W + 1;

    typedef struct packed {
        mode_e             mode;
        logic [AOFF_W-1:0] addr;
        logic              lock;
        logic [7:0]        rd_data;
        logic              rd_valid;
    } state_t;

    state_t cur_q, nxt_d;

    mode_e      dec_mode;
    logic [7:0] pg_rd_data;
    logic [7:0] sn_rd_data;
    logic       pg_wr_en_d;
    logic       wr_ok_d;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{cmd_addr[ADDR_W-1:SEL_BIT+1], cmd_addr[SEL_BIT-1:AOFF_W]};

    secreg_decode #(
        .OP_RD (OP_RD),
        .OP_WR (OP_WR)
    ) u_decode (
        .op   (cmd_op),
        .sel  (cmd_addr[SEL_BIT]),
        .mode (dec_mode)
    );

    secreg_serial_rom #(
        .SERIAL_BYTES (SERIAL_BYTES),
        .IDX_W        (IDX_W),
        .SERIAL_ID    (SERIAL_ID)
    ) u_rom (
        .idx  (cur_q.addr[IDX_W-1:0]),
        .data (sn_rd_data)
    );

    secreg_user_page #(
        .PAGE_BYTES (PAGE_BYTES),
        .IDX_W      (IDX_W)
    ) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pg_wr_en_d),
        .wr_idx  (cur_q.addr[IDX_W-1:0]),
        .wr_data (byte_in),
        .rd_idx  (cur_q.addr[IDX_W-1:0]),
        .rd_data (pg_rd_data)
    );

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.rd_valid = 1'b0;
        pg_wr_en_d     = 1'b0;
        wr_ok_d        = wel && !cur_q.lock && !(legacy_mode && (bp == 2'b11));

        if (cmd_start) begin
            nxt_d.mode = dec_mode;
            nxt_d.addr = cmd_addr[AOFF_W-1:0];
        end else begin
            if (byte_valid) begin
                unique case (cur_q.mode)
                    M_READ: begin
                        nxt_d.rd_data  = cur_q.addr[IDX_W] ? pg_rd_data : sn_rd_data;
                        nxt_d.rd_valid = 1'b1;
                        nxt_d.addr     = cur_q.addr + 1'b1;
                    end
                    M_STAT: begin
                        nxt_d.rd_data  = {7'd0, cur_q.lock};
                        nxt_d.rd_valid = 1'b1;
                    end
                    M_WRITE: begin
                        pg_wr_en_d = wr_ok_d && cur_q.addr[IDX_W];
                        nxt_d.addr[IDX_W-1:0] = cur_q.addr[IDX_W-1:0] + 1'b1;
                    end
                    M_LOCK: begin
                        if (wr_ok_d && byte_in[1]) begin
                            nxt_d.lock = 1'b1;
                        end
                    end
                    default: begin
                    end
                endcase
            end
            if (cmd_end) begin
                nxt_d.mode = M_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{mode: M_IDLE, addr: '0, lock: 1'b0, rd_data: 8'd0, rd_valid: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rd_data   = cur_q.rd_data;
    assign rd_valid  = cur_q.rd_valid;
    assign lock_flag = cur_q.lock;
endmodule

// File: rtl/secreg_checker.sv
module secreg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic       byte_valid,
    input logic       confirm_bit,
    input logic       wel,
    input logic       legacy_mode,
    input logic [1:0] bp,
    input logic       rd_valid,
    input logic       lock_flag
);
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag |=> lock_flag); // R10

    AST_LOCK_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> $past(byte_valid && confirm_bit && !cmd_start)); // R10

    AST_LOCK_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> $past(wel)); // R8

    AST_LOCK_NOT_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> !$past(legacy_mode && (bp == 2'b11))); // R9

    AST_RD_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(byte_valid && !cmd_start)); // R3
endmodule

bind secreg_ctrl secreg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .byte_valid  (byte_valid),
    .confirm_bit (byte_in[1]),
    .wel         (wel),
    .legacy_mode (legacy_mode),
    .bp          (bp),
    .rd_valid    (rd_valid),
    .lock_flag   (lock_flag)
);

// File: tb/secreg_ctrl_bench.sv
module secreg_ctrl_bench;
    localparam logic [127:0] SN = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;
    localparam logic [7:0] RD = 8'h83;
    localparam logic [7:0] WR = 8'h82;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_start, cmd_end, byte_valid, wel, legacy_mode;
    logic [7:0]  cmd_op, byte_in;
    logic [23:0] cmd_addr;
    logic [1:0]  bp;
    logic [7:0]  rd_data;
    logic        rd_valid, lock_flag;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    secreg_ctrl #(.SERIAL_ID(SN)) u_secreg_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_end(cmd_end), .byte_valid(byte_valid),
        .byte_in(byte_in), .wel(wel), .legacy_mode(legacy_mode), .bp(bp),
        .rd_data(rd_data), .rd_valid(rd_valid), .lock_flag(lock_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic start_cmd(input logic [7:0] op, input logic [23:0] a);
        cmd_start = 1'b1; cmd_op = op; cmd_addr = a;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b, output logic [7:0] d, output logic v);
        byte_valid = 1'b1; byte_in = b;
        @(negedge clk);
        byte_valid = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    task automatic stop_cmd();
        cmd_end = 1'b1;
        @(negedge clk);
        cmd_end = 1'b0;
    endtask

    task automatic read1(input logic [23:0] a, output logic [7:0] d);
        logic v;
        start_cmd(RD, a); put_byte(8'h00, d, v); stop_cmd();
    endtask

    task automatic write1(input logic [23:0] a, input logic [7:0] b);
        logic [7:0] d; logic v;
        start_cmd(WR, a); put_byte(b, d, v); stop_cmd();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 lock after reset", lock_flag, 0);
        chk("R1 rd_valid after reset", rd_valid, 0);
        read1(24'h100, d); chk("R1 page erased 0x100", d, 8'hFF);
        read1(24'h1FF, d); chk("R1 page erased 0x1FF", d, 8'hFF);
    endtask

    task automatic t_serial_read();
        logic [7:0] d; logic v;
        start_cmd(RD, 24'h00E);
        put_byte(8'h00, d, v); chk("R4 serial byte 14", d, SN[8*14 +: 8]); chk("R3 rd_valid", v, 1);
        put_byte(8'h00, d, v); chk("R4 serial byte 15", d, SN[8*15 +: 8]);
        put_byte(8'h00, d, v); chk("R4 fill 0x010", d, 8'hFF);
        put_byte(8'h00, d, v); chk("R4 fill 0x011", d, 8'hFF);
        stop_cmd();
        @(negedge clk); chk("R3 rd_valid idle", rd_valid, 0);
    endtask

    task automatic t_write_wrap();
        logic [7:0] d; logic v;
        wel = 1'b1;
        start_cmd(WR, 24'h1FE);
        put_byte(8'hA1, d, v); chk("R3 no rd_valid on write", v, 0);
        put_byte(8'hA2, d, v);
        put_byte(8'hA3, d, v);
        stop_cmd();
        start_cmd(RD, 24'h1FE);
        put_byte(8'h00, d, v); chk("R6 byte at 0x1FE", d, 8'hA1);
        put_byte(8'h00, d, v); chk("R6 byte at 0x1FF", d, 8'hA2);
        put_byte(8'h00, d, v); chk("R4 read wraps to 0x000", d, SN[7:0]);
        stop_cmd();
        read1(24'h100, d); chk("R6 write wrapped to 0x100", d, 8'hA3);
    endtask

    task automatic t_factory_write();
        logic [7:0] d;
        wel = 1'b1;
        write1(24'h010, 8'h55); read1(24'h010, d); chk("R7 fill area unchanged", d, 8'hFF);
        write1(24'h005, 8'h55); read1(24'h005, d); chk("R7 serial unchanged", d, SN[8*5 +: 8]);
        read1(24'h105, d); chk("R7 no alias into page", d, 8'hFF);
    endtask

    task automatic t_wel_gate();
        logic [7:0] d;
        wel = 1'b0;
        write1(24'h120, 8'h77); read1(24'h120, d); chk("R8 write without wel", d, 8'hFF);
        wel = 1'b1;
    endtask

    task automatic t_protect();
        logic [7:0] d;
        wel = 1'b1;
        legacy_mode = 1'b1; bp = 2'b11;
        write1(24'h130, 8'h31); read1(24'h130, d); chk("R9 legacy full protect", d, 8'hFF);
        bp = 2'b10;
        write1(24'h131, 8'h32); read1(24'h131, d); chk("R9 legacy bp=10 allows", d, 8'h32);
        legacy_mode = 1'b0; bp = 2'b11;
        write1(24'h132, 8'h33); read1(24'h132, d); chk("R9 enhanced bp=11 allows", d, 8'h33);
        bp = 2'b00;
    endtask

    task automatic t_decode();
        logic [7:0] d; logic v;
        start_cmd(8'h03, 24'h100); put_byte(8'h00, d, v); chk("R2 other opcode no data", v, 0); stop_cmd();
        start_cmd(8'h00, 24'h133); put_byte(8'h44, d, v); stop_cmd();
        read1(24'h133, d); chk("R2 other opcode no write", d, 8'hFF);
        start_cmd(RD, 24'h100);
        cmd_start = 1'b1; cmd_op = 8'h03; byte_valid = 1'b1; byte_in = 8'h00;
        @(negedge clk);
        cmd_start = 1'b0; byte_valid = 1'b0;
        chk("R11 byte with cmd_start ignored", rd_valid, 0);
        start_cmd(RD, 24'h100); stop_cmd();
        put_byte(8'h00, d, v); chk("R11 byte after cmd_end ignored", v, 0);
    endtask

    task automatic t_status(input logic [7:0] exp, input string tag);
        logic [7:0] d; logic v;
        start_cmd(RD, 24'h400);
        put_byte(8'h00, d, v); chk(tag, d, exp); chk("R3 status rd_valid", v, 1);
        put_byte(8'h00, d, v); chk(tag, d, exp);
        stop_cmd();
    endtask

    task automatic t_lock();
        logic [7:0] d; logic v;
        t_status(8'h00, "R5 status unlocked");
        wel = 1'b1;
        start_cmd(WR, 24'h400); put_byte(8'hFD, d, v); stop_cmd();
        chk("R10 no lock without bit1", lock_flag, 0);
        wel = 1'b0;
        start_cmd(WR, 24'h400); put_byte(8'h02, d, v); stop_cmd();
        chk("R8 no lock without wel", lock_flag, 0);
        wel = 1'b1; legacy_mode = 1'b1; bp = 2'b11;
        start_cmd(WR, 24'h400); put_byte(8'h02, d, v); stop_cmd();
        chk("R9 no lock when protected", lock_flag, 0);
        legacy_mode = 1'b0; bp = 2'b00;
        start_cmd(WR, 24'h400); put_byte(8'h02, d, v);
        chk("R10 lock one clock after byte", lock_flag, 1);
        stop_cmd();
        t_status(8'h01, "R5 status locked");
        write1(24'h140, 8'h99); read1(24'h140, d); chk("R8 write after lock", d, 8'hFF);
        read1(24'h131, d); chk("R10 page readable after lock", d, 8'h32);
        wel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 lock sticky", lock_flag, 1);
    endtask

    task automatic t_power_on();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 lock cleared by rst_n", lock_flag, 0);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_start = 1'b0; cmd_end = 1'b0; byte_valid = 1'b0;
        cmd_op = 8'h00; cmd_addr = '0; byte_in = 8'h00;
        wel = 1'b0; legacy_mode = 1'b0; bp = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_serial_read();
        t_write_wrap();
        t_factory_write();
        t_wel_gate();
        t_protect();
        t_decode();
        t_lock();
        t_power_on();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule